// File: doc/BRIEF.md
# Dual-Product Multiply-Accumulate Datapath

This block is a fixed-latency arithmetic pipeline that multiplies two pairs of signed 12-bit operands and adds the two products. It accepts a new set of operands on every clock. Each of the four operand ports feeds a 16-entry history line. A per-operand 4-bit select chooses how many positions back the value is taken from. Either product can have its sign flipped on its own. The sum can take a late-arriving 16-bit cascade term, a rounding bias and the previous internal total, so that long dot products or FIR taps build up over several cycles.

The internal total is 26 bits wide. A per-cycle window control chooses which 16 bits reach the output. In the normal setting the output is bits 23..8, the rounded upper part. In the swapped setting it is bits 15..0, the raw lower part. Every control bit is sampled in the same clock as the operands it acts on and travels down the pipeline with them. The one exception is the cascade word, which is sampled three clocks later so that an upstream stage has time to produce it.

Top module: `dual_mac_pipe`

## Requirements
- R1: With all delay selects 0 and no other control active, the operands sampled at clock edge k produce the output after edge k+5. With swap set the output is the low 16 bits of the two's-complement sum A*B + C*D; with swap clear it is bits 23..8 of that sum.
- R2: A delay select value d (0..15) on an operand port makes the datapath use the value that port sampled d edges before the edge that sampled the select.
- R3: `neg_ab_i` high replaces A*B by its negation, and `neg_cd_i` high replaces C*D by its negation. The two act independently.
- R4: `rnd_i` high adds 128 (bit 7) to the sum of that operand set, so that the bits 23..8 window is rounded to nearest.
- R5: `swap_i` high in an operand set makes its output bits 15..0 of the internal total; low gives bits 23..8.
- R6: The signed 16-bit `cas_i`, aligned to bit 0, is added to the sum of the operand set that was sampled three edges before the edge that samples `cas_i`.
- R7: `acc_i` high adds the previous internal total (that of the preceding operand set) to the new sum. `acc_i` low restarts the total from the new sum alone.
- R8: A low `rst_n_i` clears the output at once, and clears all history lines, pipeline registers and the accumulator. The internal reset is released on a clock edge.
- R9: Every control bit acts only on the operand set it was sampled with, even when all controls change on every clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| a_i | input | 12 | Operand A, signed |
| b_i | input | 12 | Operand B, signed |
| c_i | input | 12 | Operand C, signed |
| d_i | input | 12 | Operand D, signed |
| a_dly_i | input | 4 | History position used for A |
| b_dly_i | input | 4 | History position used for B |
| c_dly_i | input | 4 | History position used for C |
| d_dly_i | input | 4 | History position used for D |
| neg_ab_i | input | 1 | Negate A*B |
| neg_cd_i | input | 1 | Negate C*D |
| rnd_i | input | 1 | Add rounding bias 128 |
| acc_i | input | 1 | Add previous internal total |
| swap_i | input | 1 | Present low window instead of high window |
| cas_i | input | 16 | Signed cascade term, sampled three clocks after its operands |
| res_o | output | 16 | Selected 16-bit window of the internal total |

## Verification
The cascade term and the accumulator feedback both land in the same internal total. That total is then cut to the window picked by the swap bit, so one wrong alignment in any of the three shows up in a single output word. Random cascade words are driven on every clock from the cascade phase onward, while the later phases toggle accumulate, swap and rounding at random in the same cycles. Each output is judged against a bench model that rebuilds the full-width total from the operand, select and cascade history it recorded itself.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  typedef enum logic {
    WIN_HI = 1'b0,
    WIN_LO = 1'b1
  } win_e;

  // Half of one LSB of the upper window whose lowest bit sits at position lsb.
  function automatic longint unsigned round_bias(input int unsigned lsb);
    return 64'd1 << (lsb - 1);
  endfunction

endpackage

// File: rtl/dmac_rst_sync.sv
module dmac_rst_sync (
  input  logic clk_i,
  input  logic arst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/dmac_tap_line.sv
module dmac_tap_line #(
  parameter int unsigned W    = 12,
  parameter int unsigned SELW = 4
) (
  input  logic            clk_i,
  input  logic            rst_n_i,
  input  logic [W-1:0]    din_i,
  input  logic [SELW-1:0] sel_i,
  output logic [W-1:0]    tap_o
);
  localparam int unsigned DEPTH = 2 ** SELW;

  logic [W-1:0]    hist_q [DEPTH];
  logic [W-1:0]    hist_d [DEPTH];
  logic [SELW-1:0] sel_q;

  always_comb begin
    hist_d[0] = din_i;
    for (int i = 1; i < DEPTH; i++) hist_d[i] = hist_q[i-1];
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
      sel_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) hist_q[i] <= hist_d[i];
      sel_q <= sel_i;
    end
  end

  assign tap_o = hist_q[sel_q];

  // R2: a zero select hands on the value sampled in the same edge
  a_r2_zero_tap: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (sel_i == '0) |=> (tap_o == $past(din_i)));
endmodule

// File: rtl/dmac_prod_lane.sv
module dmac_prod_lane #(
  parameter int unsigned OPW = 12
) (
  input  logic                   clk_i,
  input  logic                   rst_n_i,
  input  logic [OPW-1:0]         x_i,
  input  logic [OPW-1:0]         y_i,
  input  logic                   neg_i,
  output logic signed [2*OPW:0]  n_o
);
  localparam int unsigned PW = 2 * OPW;
  localparam int unsigned NW = PW + 1;

  logic signed [PW-1:0] prod_d, prod_q;
  logic signed [NW-1:0] sgn_d, sgn_q;
  logic                 neg_q;
  logic [1:0]           warm_q, warm_d;

  always_comb begin
    prod_d = PW'($signed(x_i)) * PW'($signed(y_i));
    sgn_d  = neg_q ? -NW'(prod_q) : NW'(prod_q);
    warm_d = (warm_q == 2'd2) ? warm_q : warm_q + 2'd1;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      prod_q <= '0;
      sgn_q  <= '0;
      neg_q  <= 1'b0;
      warm_q <= '0;
    end else begin
      prod_q <= prod_d;
      sgn_q  <= sgn_d;
      neg_q  <= neg_i;
      warm_q <= warm_d;
    end
  end

  assign n_o = sgn_q;

  function automatic logic signed [NW-1:0] signed_prod(
    input logic [OPW-1:0] x, input logic [OPW-1:0] y, input logic ng);
    logic signed [NW-1:0] p;
    p = NW'($signed(x)) * NW'($signed(y));
    return ng ? -p : p;
  endfunction

  // R3: two clocks after the inputs, the lane holds the product with the requested sign
  a_r3_lane_sign: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (warm_q == 2'd2) |->
      (n_o == signed_prod($past(x_i, 2), $past(y_i, 2), $past(neg_i, 2))));
endmodule

// File: rtl/dual_mac_pipe.sv
module dual_mac_pipe
  import dmac_pkg::*;
#(
  parameter int unsigned OPW  = 12,
  parameter int unsigned SELW = 4,
  parameter int unsigned CASW = 16,
  parameter int unsigned OUTW = 16
) (
  input  logic            clk_i,
  input  logic            rst_n_i,
  input  logic [OPW-1:0]  a_i,
  input  logic [OPW-1:0]  b_i,
  input  logic [OPW-1:0]  c_i,
  input  logic [OPW-1:0]  d_i,
  input  logic [SELW-1:0] a_dly_i,
  input  logic [SELW-1:0] b_dly_i,
  input  logic [SELW-1:0] c_dly_i,
  input  logic [SELW-1:0] d_dly_i,
  input  logic            neg_ab_i,
  input  logic            neg_cd_i,
  input  logic            rnd_i,
  input  logic            acc_i,
  input  logic            swap_i,
  input  logic [CASW-1:0] cas_i,
  output logic [OUTW-1:0] res_o
);
  localparam int unsigned PW     = 2 * OPW;
  localparam int unsigned NW     = PW + 1;
  localparam int unsigned SUMW   = PW + 2;
  localparam int unsigned HI_LSB = PW - OUTW;
  localparam int unsigned NOPS   = 4;
  localparam int unsigned NLANE  = NOPS / 2;
  localparam logic [SUMW-1:0] RND_K = SUMW'(round_bias(HI_LSB));

  logic rst_ns;

  dmac_rst_sync u_rst (
    .clk_i    (clk_i),
    .arst_n_i (rst_n_i),
    .rst_n_o  (rst_ns)
  );

  // Operand history lines
  logic [OPW-1:0]  op_in  [NOPS];
  logic [SELW-1:0] sel_in [NOPS];
  logic [OPW-1:0]  op_tap [NOPS];

  assign op_in[0]  = a_i;     assign op_in[1]  = b_i;
  assign op_in[2]  = c_i;     assign op_in[3]  = d_i;
  assign sel_in[0] = a_dly_i; assign sel_in[1] = b_dly_i;
  assign sel_in[2] = c_dly_i; assign sel_in[3] = d_dly_i;

  for (genvar g = 0; g < NOPS; g++) begin : g_tap
    dmac_tap_line #(.W(OPW), .SELW(SELW)) u_line (
      .clk_i   (clk_i),
      .rst_n_i (rst_ns),
      .din_i   (op_in[g]),
      .sel_i   (sel_in[g]),
      .tap_o   (op_tap[g])
    );
  end

  // Product lanes
  logic [NLANE-1:0]     neg_q;
  logic signed [NW-1:0] lane_n [NLANE];

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    dmac_prod_lane #(.OPW(OPW)) u_lane (
      .clk_i   (clk_i),
      .rst_n_i (rst_ns),
      .x_i     (op_tap[2*l]),
      .y_i     (op_tap[2*l+1]),
      .neg_i   (neg_q[l]),
      .n_o     (lane_n[l])
    );
  end

  // Control alignment, sum, accumulate and window
  logic [2:0]      rnd_sr,  rnd_sr_d;
  logic [3:0]      acc_sr,  acc_sr_d;
  logic [4:0]      swap_sr, swap_sr_d;
  logic [SUMW-1:0] psum_q,  psum_d;
  logic [SUMW-1:0] acc_q,   acc_d;
  logic [OUTW-1:0] res_q,   res_d;
  win_e            win_sel;

  assign win_sel = win_e'(swap_sr[4]);

  always_comb begin
    rnd_sr_d  = {rnd_sr[1:0],  rnd_i};
    acc_sr_d  = {acc_sr[2:0],  acc_i};
    swap_sr_d = {swap_sr[3:0], swap_i};
    psum_d = SUMW'(lane_n[0]) + SUMW'(lane_n[1])
           + (rnd_sr[2] ? RND_K : '0)
           + SUMW'($signed(cas_i));
    acc_d  = psum_q + (acc_sr[3] ? acc_q : '0);
    res_d  = (win_sel == WIN_LO) ? acc_q[OUTW-1:0]
                                 : acc_q[HI_LSB+OUTW-1:HI_LSB];
  end

  always_ff @(posedge clk_i or negedge rst_ns) begin
    if (!rst_ns) begin
      neg_q   <= '0;
      rnd_sr  <= '0;
      acc_sr  <= '0;
      swap_sr <= '0;
      psum_q  <= '0;
      acc_q   <= '0;
      res_q   <= '0;
    end else begin
      neg_q   <= {neg_cd_i, neg_ab_i};
      rnd_sr  <= rnd_sr_d;
      acc_sr  <= acc_sr_d;
      swap_sr <= swap_sr_d;
      psum_q  <= psum_d;
      acc_q   <= acc_d;
      res_q   <= res_d;
    end
  end

  assign res_o = res_q;

  // R7: accumulate folds in the previous total
  a_r7_accum: assert property (@(posedge clk_i) disable iff (!rst_ns)
    acc_sr[3] |=> (acc_q == $past(acc_q) + $past(psum_q)));
  // R7: without accumulate the total restarts from the new sum
  a_r7_restart: assert property (@(posedge clk_i) disable iff (!rst_ns)
    !acc_sr[3] |=> (acc_q == $past(psum_q)));
  // R5: swapped window shows the low bits of the total
  a_r5_low_window: assert property (@(posedge clk_i) disable iff (!rst_ns)
    swap_sr[4] |=> (res_o == $past(acc_q[OUTW-1:0])));
  // R5: normal window shows the upper bits of the total
  a_r5_high_window: assert property (@(posedge clk_i) disable iff (!rst_ns)
    !swap_sr[4] |=> (res_o == $past(acc_q[HI_LSB+OUTW-1:HI_LSB])));
endmodule

// File: tb/dual_mac_pipe_tb_top.sv
`timescale 1ns/1ps
module dual_mac_pipe_tb_top;
  localparam int N   = 528;
  localparam int LAT = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] a, b, c, d;
  logic [3:0]  ad, bd, cd, dd;
  logic        nab, ncd, rnd, acc, swp;
  logic [15:0] cas;
  logic [15:0] res;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dual_mac_pipe dut_i (
    .clk_i(clk), .rst_n_i(rst_n),
    .a_i(a), .b_i(b), .c_i(c), .d_i(d),
    .a_dly_i(ad), .b_dly_i(bd), .c_dly_i(cd), .d_dly_i(dd),
    .neg_ab_i(nab), .neg_cd_i(ncd), .rnd_i(rnd), .acc_i(acc), .swap_i(swp),
    .cas_i(cas), .res_o(res)
  );

  logic [11:0] ah [0:1023], bh [0:1023], ch [0:1023], dh [0:1023];
  logic [3:0]  adh[0:1023], bdh[0:1023], cdh[0:1023], ddh[0:1023];
  logic        nabh[0:1023], ncdh[0:1023], rndh[0:1023], acch[0:1023], swph[0:1023];
  logic [15:0] cash[0:1023];
  string       tagh[0:1023];
  longint      m_acc = 0;

  function automatic longint sx(input logic [11:0] v);
    return longint'($signed(v));
  endfunction

  function automatic logic [11:0] past_op(input int which, input int j);
    if (j < 0) return 12'd0;
    case (which)
      0: return ah[j];
      1: return bh[j];
      2: return ch[j];
      default: return dh[j];
    endcase
  endfunction

  // Reference result for operand set k, advancing the model accumulator.
  function automatic logic [15:0] model_out(input int k);
    longint pab, pcd, ps;
    logic [63:0] v;
    pab = sx(past_op(0, k - int'(adh[k]))) * sx(past_op(1, k - int'(bdh[k])));
    pcd = sx(past_op(2, k - int'(cdh[k]))) * sx(past_op(3, k - int'(ddh[k])));
    if (nabh[k]) pab = -pab;
    if (ncdh[k]) pcd = -pcd;
    ps = pab + pcd + (rndh[k] ? 64'sd128 : 64'sd0) + longint'($signed(cash[k+3]));
    m_acc = (acch[k] ? m_acc : 0) + ps;
    v = m_acc;
    return swph[k] ? v[15:0] : v[23:8];
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp, input int k);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s op=%0d got=%h exp=%h", tag, k, got, exp);
    end
  endtask

  task automatic idle_inputs();
    a = 0; b = 0; c = 0; d = 0; ad = 0; bd = 0; cd = 0; dd = 0;
    nab = 0; ncd = 0; rnd = 0; acc = 0; swp = 0; cas = 0;
  endtask

  // Pick stimulus for index n and record it.
  task automatic gen(input int n);
    logic [11:0] ra, rb, rc, rd;
    ra = 12'($urandom); rb = 12'($urandom); rc = 12'($urandom); rd = 12'($urandom);
    idle_inputs();
    a = ra; b = rb; c = rc; d = rd;
    if (n >= 131 && n < N + 3) cas = 16'($urandom);
    if (n < 8) begin
      tagh[n] = "R1";
      case (n)
        0: begin a = 12'd3; b = 12'd5; c = 12'hFFE; d = 12'd7; swp = 1; end
        1: begin a = 12'h800; b = 12'h800; c = 12'h800; d = 12'h800; end
        2: begin a = 12'h7FF; b = 12'h7FF; c = 12'h7FF; d = 12'h7FF; end
        3: begin a = 12'h800; b = 12'h7FF; c = 12'h7FF; d = 12'h800; swp = 1; end
        4: begin a = 12'h800; b = 12'h7FF; c = 12'h800; d = 12'h7FF; end
        default: swp = n[0];
      endcase
    end else if (n < 48) begin
      tagh[n] = "R3"; nab = 1'($urandom); ncd = 1'($urandom); swp = 1'($urandom);
    end else if (n < 88) begin
      tagh[n] = "R4"; rnd = 1'($urandom);
    end else if (n < 128) begin
      tagh[n] = "R5"; swp = 1'($urandom); rnd = 1'($urandom);
    end else if (n < 168) begin
      tagh[n] = "R6"; swp = 1'($urandom);
    end else if (n < 248) begin
      tagh[n] = "R2";
      ad = 4'($urandom); bd = 4'($urandom); cd = 4'($urandom); dd = 4'($urandom);
      swp = 1'($urandom);
      if (n == 200) begin ad = 4'd15; bd = 4'd15; cd = 4'd15; dd = 4'd15; end
    end else if (n < 328) begin
      tagh[n] = "R7"; acc = ($urandom % 4) != 0; swp = 1'($urandom); rnd = 1'($urandom);
    end else if (n < N) begin
      tagh[n] = "R9";
      ad = 4'($urandom); bd = 4'($urandom); cd = 4'($urandom); dd = 4'($urandom);
      nab = 1'($urandom); ncd = 1'($urandom); rnd = 1'($urandom);
      acc = 1'($urandom); swp = 1'($urandom);
    end else begin
      tagh[n] = "R1"; a = 0; b = 0; c = 0; d = 0;
    end
    ah[n] = a; bh[n] = b; ch[n] = c; dh[n] = d;
    adh[n] = ad; bdh[n] = bd; cdh[n] = cd; ddh[n] = dd;
    nabh[n] = nab; ncdh[n] = ncd; rndh[n] = rnd; acch[n] = acc; swph[n] = swp;
    cash[n] = cas;
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R8", res, 16'h0000, -1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R8", res, 16'h0000, -1);

    for (int n = 0; n < N + LAT + 2; n++) begin
      int k;
      k = n - LAT - 1;
      if (k >= 0 && k < N) check(tagh[k], res, model_out(k), k);
      gen(n);
      @(negedge clk);
    end

    // R8: reset in mid-stream clears output at once and wipes all state
    gen(N);
    a = 12'h7FF; b = 12'h7FF; acc = 1; swp = 1;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R8", res, 16'h0000, -2);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle_inputs();
    acc = 1; swp = 1; ad = 4'd15; bd = 4'd7; cd = 4'd15; dd = 4'd3;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      check("R8", res, 16'h0000, -3);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule